// File: doc/BRIEF.md
# Per-Channel Output Drive Selection

This block works out the on/off request for each of eight low-side power channels. Each channel has a serial command bit, written by the serial interface logic that sits in front of this block. Most channels also have a parallel term that comes from one of four external input pins. A per-channel mode bit chooses whether the serial bit and the parallel term are combined by logical AND or by logical OR. The result is registered and goes to the channel's protection logic as a drive request.

A single polarity pin sets the active level of all four parallel pins. Each pin also has a valid flag, so a pin that is left floating always reads as inactive. Pins one to three are tied to channels one to three. The fourth pin can be routed to any non-empty set of channels through a mapping register. A per-channel slew-speed bit is stored and passed out unchanged for the output stage. While reset is held low, all configuration is cleared and every drive request is off.

Configuration is written one register at a time through a select code and an 8-bit data word. The top level holds the configuration registers and the registered drive requests.

Top module: `dt_drive_sel`

## Requirements
- R1: Serial on bits are active high. A write with select code 0 loads them, with bit i belonging to channel i+1. In OR mode with no active parallel term, drive_req[i] equals the on bit.
- R2: When pol_hi is 1, a valid parallel pin is active when it is high. When pol_hi is 0, a valid parallel pin is active when it is low.
- R3: A mode bit of 1 (written with select code 1) selects AND. A channel in AND mode that has a parallel term is on only when its serial bit is 1 and its parallel term is active.
- R4: A mode bit of 0 selects OR. The channel is on when its serial bit is 1 or its parallel term is active.
- R5: Parallel pins 0 to 2 always form the parallel term of channels bits 0 to 2.
- R6: The map register (select code 2) routes parallel pin 3 to every channel whose map bit is 1. Its reset value is 8'h08, which maps pin 3 to channel bit 3 only.
- R7: A write of zero to the map register is ignored, so at least one channel stays mapped.
- R8: A channel with neither its own pin nor a map bit has a neutral parallel term: 0 in OR mode and 1 in AND mode. The serial bit alone then controls it.
- R9: A parallel pin whose valid flag is 0 is inactive at either polarity.
- R10: While rst_n is low, drive_req is 0. Reset also clears all on bits, mode bits (to OR) and slew bits, and restores the map to 8'h08.
- R11: The slew bits (select code 3, 1 = fast) appear unchanged on slew_fast.
- R12: drive_req follows a pin change at the next clock edge. It follows a configuration write at the second clock edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset / sleep |
| pol_hi | input | 1 | Parallel pin polarity: 1 = active high, 0 = active low |
| par_pin | input | 4 | Parallel input pin levels |
| par_valid | input | 4 | 1 when the matching pin is connected |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 on, 1 mode, 2 map, 3 slew |
| cfg_wdata | input | 8 | Write data, one bit per channel |
| drive_req | output | 8 | Registered per-channel drive request |
| slew_fast | output | 8 | Stored per-channel slew-speed select |

## Verification
The hardest situations to reach are those where the remapped fourth pin meets a channel in AND mode. Reaching them needs the map, the mode bits and the on bits all in unusual states at once, and then a pin-level pattern that tells apart a neutral term, a mapped term and a floating pin. Directed sequences first set up the map so it leaves channel 4 unmapped while the upper channels are mapped, and then try a zero map write. Seeded random traffic then interleaves register writes, including zero map data, with random pin levels, valid flags and polarity. Every cycle is compared against a bench model.

// File: rtl/dt_pkg.sv
package dt_pkg;
    parameter int NUM_CH  = 8;
    parameter int NUM_PIN = 4;
    localparam int MAP_PIN = NUM_PIN - 1;
    localparam logic [NUM_CH-1:0] MAP_RESET = NUM_CH'(1) << MAP_PIN;

    typedef enum logic [1:0] {
        SEL_ON   = 2'd0,
        SEL_MODE = 2'd1,
        SEL_MAP  = 2'd2,
        SEL_SLEW = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [NUM_CH-1:0] on;
        logic [NUM_CH-1:0] and_mode;
        logic [NUM_CH-1:0] map;
        logic [NUM_CH-1:0] fast;
    } cfg_t;
endpackage

// File: rtl/dt_cfg_regs.sv
module dt_cfg_regs
    import dt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [NUM_CH-1:0] wdata,
    output cfg_t              cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (cfg_sel_e'(sel))
                SEL_ON:   cfg_d.on       = wdata;
                SEL_MODE: cfg_d.and_mode = wdata;
                SEL_MAP:  if (wdata != '0) cfg_d.map = wdata;
                SEL_SLEW: cfg_d.fast     = wdata;
                default:  cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.on       <= '0;
            cfg_q.and_mode <= '0;
            cfg_q.map      <= MAP_RESET;
            cfg_q.fast     <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

    // R7
    map_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.map != '0);

    // R7
    map_zero_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == 2'd2 && wdata == '0) |=> $stable(cfg_q.map));

    // R11
    slew_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == 2'd3) |=> (cfg_q.fast == $past(wdata)));
endmodule

// File: rtl/dt_pin_cond.sv
module dt_pin_cond
    import dt_pkg::*;
(
    input  logic               pol_hi,
    input  logic [NUM_PIN-1:0] pin,
    input  logic [NUM_PIN-1:0] valid,
    output logic [NUM_PIN-1:0] act
);
    for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
        always_comb begin
            act[p] = valid[p] & (pol_hi ? pin[p] : ~pin[p]);
        end
    end
endmodule

// File: rtl/dt_chan_mix.sv
module dt_chan_mix
    import dt_pkg::*;
(
    input  cfg_t               cfg,
    input  logic [NUM_PIN-1:0] act,
    output logic [NUM_CH-1:0]  cmd
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic own_term;
        logic has_term;
        logic par_term;

        if (c < MAP_PIN) begin : g_fixed
            assign own_term = act[c];
            assign has_term = 1'b1;
        end else begin : g_free
            assign own_term = 1'b0;
            assign has_term = cfg.map[c];
        end

        always_comb begin
            par_term = own_term | (cfg.map[c] & act[MAP_PIN]);
            if (cfg.and_mode[c]) begin
                cmd[c] = cfg.on[c] & (has_term ? par_term : 1'b1);
            end else begin
                cmd[c] = cfg.on[c] | par_term;
            end
        end
    end
endmodule

// File: rtl/dt_drive_sel.sv
module dt_drive_sel
    import dt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pol_hi,
    input  logic [NUM_PIN-1:0] par_pin,
    input  logic [NUM_PIN-1:0] par_valid,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [NUM_CH-1:0]  cfg_wdata,
    output logic [NUM_CH-1:0]  drive_req,
    output logic [NUM_CH-1:0]  slew_fast
);
    cfg_t               cfg;
    logic [NUM_PIN-1:0] act;
    logic [NUM_CH-1:0]  cmd;
    logic [NUM_CH-1:0]  drive_d, drive_q;

    dt_cfg_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    dt_pin_cond u_pins (
        .pol_hi (pol_hi),
        .pin    (par_pin),
        .valid  (par_valid),
        .act    (act)
    );

    dt_chan_mix u_mix (
        .cfg (cfg),
        .act (act),
        .cmd (cmd)
    );

    always_comb begin
        drive_d = cmd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) drive_q <= '0;
        else        drive_q <= drive_d;
    end

    assign drive_req = drive_q;
    assign slew_fast = cfg.fast;

    // R3
    and_serial_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.on == '0 && cfg.and_mode == '1) |=> (drive_q == '0));

    // R4
    or_serial_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.on == '1 && cfg.and_mode == '0) |=> (drive_q == '1));

    // R9
    floating_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (par_valid == '0 && cfg.on == '0) |=> (drive_q == '0));
endmodule

// File: tb/dt_drive_sel_bench.sv
module dt_drive_sel_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pol_hi = 1'b1;
    logic [3:0] par_pin = '0;
    logic [3:0] par_valid = '1;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] drive_req, slew_fast;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_on, m_and, m_map, m_fast;

    always #2 clk = ~clk;

    dt_drive_sel u_dt_drive_sel (
        .clk(clk), .rst_n(rst_n), .pol_hi(pol_hi), .par_pin(par_pin),
        .par_valid(par_valid), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .drive_req(drive_req), .slew_fast(slew_fast)
    );

    function automatic logic [7:0] exp_drive(logic [3:0] pin, logic [3:0] vld, logic pol);
        logic [3:0] a;
        logic [7:0] r;
        for (int p = 0; p < 4; p++) a[p] = vld[p] & (pol ? pin[p] : ~pin[p]);
        for (int c = 0; c < 8; c++) begin
            logic own, has, pt;
            own = (c < 3) ? a[c] : 1'b0;
            has = (c < 3) ? 1'b1 : m_map[c];
            pt  = own | (m_map[c] & a[3]);
            r[c] = m_and[c] ? (m_on[c] & (has ? pt : 1'b1)) : (m_on[c] | pt);
        end
        return r;
    endfunction

    task automatic model_reset();
        m_on = '0; m_and = '0; m_map = 8'h08; m_fast = '0;
    endtask

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // drive stimulus at a negedge, check two negedges later
    task automatic step(logic w, logic [1:0] s, logic [7:0] d,
                        logic [3:0] pin, logic [3:0] vld, logic pol, string tag);
        @(negedge clk);
        cfg_we = w; cfg_sel = s; cfg_wdata = d;
        par_pin = pin; par_valid = vld; pol_hi = pol;
        if (w) begin
            case (s)
                2'd0: m_on = d;
                2'd1: m_and = d;
                2'd2: if (d != 0) m_map = d;
                default: m_fast = d;
            endcase
        end
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
        chk(tag, drive_req, exp_drive(pin, vld, pol));
        chk({tag, " slew"}, slew_fast, m_fast);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        #1;
        chk("R10 drive in reset", drive_req, 8'h00);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 drive after reset", drive_req, 8'h00);
        chk("R10 slew after reset", slew_fast, 8'h00);

        step(0, 0, 0, 4'b1000, 4'hF, 1, "R6 default map");
        step(0, 0, 0, 4'b0111, 4'hF, 1, "R5 fixed pins");
        step(0, 0, 0, 4'b0000, 4'hF, 0, "R2 active low");
        step(0, 0, 0, 4'b1111, 4'hF, 1, "R2 active high");
        step(0, 0, 0, 4'b0000, 4'h0, 0, "R9 float low pol");
        step(0, 0, 0, 4'b1111, 4'h0, 1, "R9 float high pol");
        step(1, 0, 8'hA5, 4'b0000, 4'hF, 1, "R1 serial bits");
        step(1, 0, 8'hFF, 4'b0001, 4'hF, 1, "R1 serial all on");
        step(1, 1, 8'hFF, 4'b0001, 4'hF, 1, "R3 and mode");
        chk("R8 neutral and", drive_req, 8'hF1);
        step(1, 0, 8'h00, 4'b0010, 4'hF, 1, "R3 and serial off");
        step(1, 1, 8'h00, 4'b0010, 4'hF, 1, "R4 or mode");
        step(1, 2, 8'hF0, 4'b1000, 4'hF, 1, "R6 remap");
        chk("R8 unmapped ch4", drive_req & 8'h08, 8'h00);
        step(1, 2, 8'h00, 4'b1000, 4'hF, 1, "R7 zero map");
        chk("R7 map kept", drive_req, 8'hF0);
        step(1, 3, 8'h3C, 4'b0000, 4'hF, 1, "R11 slew");

        // R12: pin change seen after a single edge
        @(negedge clk);
        par_pin = 4'b0001;
        @(negedge clk);
        chk("R12 pin latency", drive_req, exp_drive(par_pin, par_valid, pol_hi));

        // R10: reset mid-run
        step(1, 0, 8'hFF, 4'b0000, 4'hF, 1, "R1 before reset");
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R10 drive forced off", drive_req, 8'h00);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
        par_pin = 4'b0100;
        @(negedge clk);
        chk("R10 only parallel", drive_req, 8'h04);
        chk("R10 slew cleared", slew_fast, 8'h00);

        for (int i = 0; i < 400; i++) begin
            logic [7:0] d;
            d = ($urandom % 4 == 0) ? 8'h00 : 8'($urandom);
            step(($urandom % 2) == 1, 2'($urandom), d, 4'($urandom), 4'($urandom),
                 1'($urandom), "R12 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule